// File: doc/BRIEF.md
# Event Interrupt Controller

This block gathers a small set of single-bit event inputs and turns them into one interrupt request. Each input is bound at build time to a detection mode (level, rising edge or falling edge). A per-event pending flag latches according to that mode, a per-event enable mask selects which pending flags may raise the interrupt, and the interrupt line is the OR of every pending flag whose enable is set.

Software reaches three byte-wide registers through a small single-beat slave port in the Wishbone style. The first returns the live input levels, the second shows the pending flags and clears them on a write of ones, and the third is the enable mask. Every accepted access is acknowledged exactly one cycle later. The asynchronous active-low reset is released to the logic through a short synchronizer.

Top module: `evt_irq_ctrl`

## Requirements
- R1: A read at offset 0 returns the present level of every event input, event i in data bit i and zeros above the last event. A write to offset 0 changes no register.
- R2: Offset 2 is a read/write enable mask with one bit per event. It resets to 0 and changes only on a write to offset 2. Data bits above the last event are dropped and read back as 0.
- R3: Offset 1 returns the pending flags. Writing a 1 to a pending bit clears it. Writing a 0 leaves that bit unchanged.
- R4: A level-mode event (mode code 0) sets its pending bit on every clock edge at which its input is high. A clear written while the input is still high leaves the bit set.
- R5: A rise-mode event (mode code 1) sets its pending bit on a 0-to-1 input transition, and the bit holds until cleared. The remembered previous level resets to 0, so an input that is high when reset is released counts as a rising edge.
- R6: A fall-mode event (mode code 2) sets its pending bit on a 1-to-0 input transition, and the bit holds until cleared.
- R7: When a detection and a software clear reach the same pending bit at the same clock edge, the bit ends up set.
- R8: The interrupt output is the OR over all events of (pending AND enable). It stays low while the enable mask is zero, whatever is pending.
- R9: A write that clears the last enabled pending bit brings the interrupt low in the same cycle in which its acknowledge is high.
- R10: An access is accepted when cycle and strobe are both high and no acknowledge is showing. The acknowledge is high for exactly the one cycle after acceptance. Strobe without cycle is never acknowledged, and a held request is acknowledged on alternate cycles.
- R11: A read at offset 3 returns 0. A write to offset 3 changes no register.

Mode codes are packed two bits per event, event i in bits [2i+1:2i]. The default configuration is event 0 level, event 1 rise and event 2 fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_EVT | Event inputs, one bit per event |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write when high, read when low |
| wb_adr_i | input | 2 | Register offset |
| wb_dat_i | input | 8 | Write data |
| wb_dat_o | output | 8 | Read data, valid while acknowledge is high |
| wb_ack_o | output | 1 | Single-cycle acknowledge |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench clears a level event while its input is still high. A design that honoured that clear would drop the flag and lose the request. It also fires a rising edge at the same edge as a clear of that bit, where a clear-first design would swallow the event. An event held high across reset must show up as a rising edge, or software would never learn of a source that was already asserted. The interrupt is checked in the acknowledge cycle of the clearing write, which catches an extra register stage in the interrupt path. Random bus traffic to every offset, including the unused one and the read-only status, is compared against a model on each access and on every cycle of the interrupt. That comparison exposes stray writes, unmasked high data bits and acknowledges that last longer than one cycle.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int unsigned BUS_DW = 8;
  localparam int unsigned BUS_AW = 2;

  typedef enum logic [1:0] {
    DET_LEVEL = 2'd0,
    DET_RISE  = 2'd1,
    DET_FALL  = 2'd2
  } det_mode_e;

  localparam logic [BUS_AW-1:0] OFS_STATUS = 2'd0;
  localparam logic [BUS_AW-1:0] OFS_PEND   = 2'd1;
  localparam logic [BUS_AW-1:0] OFS_ENABLE = 2'd2;
  localparam logic [BUS_AW-1:0] OFS_SPARE  = 2'd3;

endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/evt_detect.sv
module evt_detect
  import evt_irq_pkg::*;
#(
  parameter int unsigned          NUM_EVT = 3,
  parameter logic [2*NUM_EVT-1:0] MODES   = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [NUM_EVT-1:0] set_o
);

  generate
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
      localparam det_mode_e MODE = det_mode_e'(MODES[2*i +: 2]);

      if (MODE == DET_RISE || MODE == DET_FALL) begin : g_edge
        // previous-level flop exists only for edge-sensitive sources
        logic prev_q;
        logic prev_d;

        always_comb begin
          prev_d = evt_i[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            prev_q <= 1'b0;
          end else begin
            prev_q <= prev_d;
          end
        end

        if (MODE == DET_RISE) begin : g_rise
          assign set_o[i] = evt_i[i] & ~prev_q;
        end else begin : g_fall
          assign set_o[i] = ~evt_i[i] & prev_q;
        end
      end else begin : g_level
        assign set_o[i] = evt_i[i];
      end
    end
  endgenerate

endmodule

// File: rtl/evt_bus_slave.sv
module evt_bus_slave
  import evt_irq_pkg::*;
#(
  parameter int unsigned NUM_EVT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_i,
  input  logic               stb_i,
  input  logic               we_i,
  input  logic [BUS_AW-1:0]  adr_i,
  input  logic [BUS_DW-1:0]  dat_i,
  output logic [BUS_DW-1:0]  dat_o,
  output logic               ack_o,
  input  logic [NUM_EVT-1:0] status_i,
  input  logic [NUM_EVT-1:0] pend_i,
  input  logic [NUM_EVT-1:0] en_i,
  output logic [NUM_EVT-1:0] clr_o,
  output logic               en_we_o,
  output logic [NUM_EVT-1:0] en_wdata_o
);

  localparam int PAD_W = int'(BUS_DW) - int'(NUM_EVT);

  function automatic logic [BUS_DW-1:0] widen(input logic [NUM_EVT-1:0] v);
    logic [BUS_DW-1:0] r;
    r              = '0;
    r[NUM_EVT-1:0] = v;
    return r;
  endfunction

  logic              ack_q;
  logic              ack_d;
  logic [BUS_DW-1:0] rdat_q;
  logic [BUS_DW-1:0] rdat_d;
  logic [BUS_DW-1:0] rsel;
  logic              accept;
  logic              rd_go;
  logic              wr_go;

  always_comb begin
    accept = cyc_i & stb_i & ~ack_q;
    rd_go  = accept & ~we_i;
    wr_go  = accept & we_i;

    case (adr_i)
      OFS_STATUS: rsel = widen(status_i);
      OFS_PEND:   rsel = widen(pend_i);
      OFS_ENABLE: rsel = widen(en_i);
      default:    rsel = '0;
    endcase

    ack_d      = accept;
    rdat_d     = rd_go ? rsel : '0;
    clr_o      = (wr_go && adr_i == OFS_PEND) ? dat_i[NUM_EVT-1:0] : '0;
    en_we_o    = wr_go && (adr_i == OFS_ENABLE);
    en_wdata_o = dat_i[NUM_EVT-1:0];
  end

  generate
    if (PAD_W > 0) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^dat_i[BUS_DW-1:NUM_EVT];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      rdat_q <= '0;
    end else begin
      ack_q  <= ack_d;
      rdat_q <= rdat_d;
    end
  end

  assign ack_o = ack_q;
  assign dat_o = rdat_q;

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q); // R10

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> $past(cyc_i && stb_i)); // R10

  AST_SPARE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && $past(!we_i && adr_i == OFS_SPARE)) |-> (rdat_q == '0)); // R11

endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs #(
  parameter int unsigned NUM_EVT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] set_i,
  input  logic [NUM_EVT-1:0] clr_i,
  input  logic               en_we_i,
  input  logic [NUM_EVT-1:0] en_wdata_i,
  output logic [NUM_EVT-1:0] pend_o,
  output logic [NUM_EVT-1:0] en_o,
  output logic               irq_o
);

  logic [NUM_EVT-1:0] pend_q;
  logic [NUM_EVT-1:0] pend_d;
  logic [NUM_EVT-1:0] en_q;
  logic [NUM_EVT-1:0] en_d;
  logic               armed_q;

  always_comb begin
    // set is applied after the clear, so a same-edge detection survives
    pend_d = (pend_q & ~clr_i) | set_i;
    en_d   = en_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      en_q    <= '0;
      armed_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      armed_q <= 1'b1;
      if (en_we_i) begin
        en_q <= en_d;
      end
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = |(pend_q & en_q);

  AST_EN_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !$past(en_we_i)) |-> $stable(en_q)); // R2

  generate
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_chk
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(set_i[i])) |-> pend_q[i]); // R7

      AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(pend_q[i] && !clr_i[i])) |-> pend_q[i]); // R5 R6

      AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(clr_i[i] && !set_i[i])) |-> !pend_q[i]); // R3
    end
  endgenerate

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned          NUM_EVT    = 3,
  parameter logic [2*NUM_EVT-1:0] MODES      = 6'b10_01_00,
  parameter int unsigned          RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               wb_cyc_i,
  input  logic               wb_stb_i,
  input  logic               wb_we_i,
  input  logic [1:0]         wb_adr_i,
  input  logic [7:0]         wb_dat_i,
  output logic [7:0]         wb_dat_o,
  output logic               wb_ack_o,
  output logic               irq_o
);

  logic               rst_core_n;
  logic [NUM_EVT-1:0] set_w;
  logic [NUM_EVT-1:0] clr_w;
  logic [NUM_EVT-1:0] pend_w;
  logic [NUM_EVT-1:0] en_w;
  logic [NUM_EVT-1:0] en_wdata_w;
  logic               en_we_w;

  evt_rst_sync #(
    .STAGES(RST_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_core_n)
  );

  evt_detect #(
    .NUM_EVT(NUM_EVT),
    .MODES  (MODES)
  ) u_detect (
    .clk  (clk),
    .rst_n(rst_core_n),
    .evt_i(evt_i),
    .set_o(set_w)
  );

  evt_irq_regs #(
    .NUM_EVT(NUM_EVT)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .set_i     (set_w),
    .clr_i     (clr_w),
    .en_we_i   (en_we_w),
    .en_wdata_i(en_wdata_w),
    .pend_o    (pend_w),
    .en_o      (en_w),
    .irq_o     (irq_o)
  );

  evt_bus_slave #(
    .NUM_EVT(NUM_EVT)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cyc_i     (wb_cyc_i),
    .stb_i     (wb_stb_i),
    .we_i      (wb_we_i),
    .adr_i     (wb_adr_i),
    .dat_i     (wb_dat_i),
    .dat_o     (wb_dat_o),
    .ack_o     (wb_ack_o),
    .status_i  (evt_i),
    .pend_i    (pend_w),
    .en_i      (en_w),
    .clr_o     (clr_w),
    .en_we_o   (en_we_w),
    .en_wdata_o(en_wdata_w)
  );

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_core_n)
    (en_w == '0) |-> !irq_o); // R8

  AST_STATUS_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wb_ack_o && $past(wb_we_i && wb_adr_i == OFS_STATUS)) |-> $stable(en_w)); // R1

endmodule

// File: tb/evt_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module evt_irq_ctrl_tb_top;

  localparam int          NE       = 3;
  localparam logic [5:0]  MODES_TB = 6'b10_01_00;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] ev;
  logic       cyc, stb, we;
  logic [1:0] adr;
  logic [7:0] wdat;
  logic [7:0] dat_r;
  logic       ack;
  logic       irq;

  int  checks   = 0;
  int  failures = 0;
  bit  mon_on   = 1'b0;
  bit  finished = 1'b0;
  logic irq_at_ack;

  always #10 clk = ~clk;

  evt_irq_ctrl #(.NUM_EVT(NE), .MODES(MODES_TB)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(ev),
    .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
    .wb_dat_i(wdat), .wb_dat_o(dat_r), .wb_ack_o(ack), .irq_o(irq)
  );

  // ---------------- reference model ----------------
  logic [2:0] m_pend, m_en, m_prev;
  logic       m_ack;
  logic [7:0] m_rdata;
  logic       m_irq;

  function automatic logic [2:0] exp_set(input logic [2:0] cur, input logic [2:0] prv);
    logic [2:0] s;
    for (int i = 0; i < NE; i++) begin
      case (MODES_TB[2*i +: 2])
        2'd1:    s[i] = cur[i] & ~prv[i];
        2'd2:    s[i] = ~cur[i] & prv[i];
        default: s[i] = cur[i];
      endcase
    end
    return s;
  endfunction

  function automatic logic [7:0] exp_read(input logic [1:0] a, input logic [2:0] st,
                                          input logic [2:0] pd, input logic [2:0] en);
    case (a)
      2'd0:    return {5'b0, st};
      2'd1:    return {5'b0, pd};
      2'd2:    return {5'b0, en};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= '0; m_en <= '0; m_prev <= '0; m_ack <= 1'b0; m_rdata <= '0;
    end else begin : mdl
      logic acc;
      logic [2:0] clr;
      acc = cyc & stb & ~m_ack;
      clr = (acc && we && adr == 2'd1) ? wdat[2:0] : 3'b000;
      m_pend  <= (m_pend & ~clr) | exp_set(ev, m_prev);
      if (acc && we && adr == 2'd2) m_en <= wdat[2:0];
      m_prev  <= ev;
      m_ack   <= acc;
      m_rdata <= (acc && !we) ? exp_read(adr, ev, m_pend, m_en) : 8'h00;
    end
  end

  assign m_irq = |(m_pend & m_en);

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) chk(irq === m_irq, "R8 irq vs model", {7'b0, irq}, {7'b0, m_irq});
  end

  // called at a negedge; returns at a negedge with the bus idle for one cycle
  task automatic xfer(input bit w, input logic [1:0] a, input logic [7:0] d,
                      input string tag, output logic [7:0] r);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
    @(negedge clk);
    chk(ack === 1'b1, "R10 ack one cycle after request", {7'b0, ack}, 8'h01);
    r = dat_r;
    irq_at_ack = irq;
    if (!w) chk(dat_r === m_rdata, tag, dat_r, m_rdata);
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(negedge clk);
    chk(ack === 1'b0, "R10 ack is one cycle wide", {7'b0, ack}, 8'h00);
  endtask

  task automatic rd_expect(input logic [1:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] r;
    xfer(1'b0, a, 8'h00, tag, r);
    chk(r === exp, tag, r, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] r;
    xfer(1'b1, a, d, "write", r);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] r;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ev = 3'b010; cyc = 0; stb = 0; we = 0; adr = 0; wdat = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    mon_on = 1'b1;

    chk(ack === 1'b0 && irq === 1'b0, "reset outputs idle", {6'b0, ack, irq}, 8'h00);
    rd_expect(2'd2, 8'h00, "R2 enable resets to zero");
    rd_expect(2'd1, 8'h02, "R5 input high out of reset is a rising edge");
    rd_expect(2'd0, 8'h02, "R1 status mirrors inputs");
    wr(2'd1, 8'h02);
    rd_expect(2'd1, 8'h00, "R3 write one clears pending");

    ev = 3'b101;
    repeat (2) @(negedge clk);
    chk(irq === 1'b0, "R8 irq low with enable zero", {7'b0, irq}, 8'h00);
    rd_expect(2'd0, 8'h05, "R1 status 101");
    rd_expect(2'd1, 8'h01, "R4 level pending set, rise/fall quiet");
    wr(2'd2, 8'h07);
    chk(irq === 1'b1, "R8 irq after enable", {7'b0, irq}, 8'h01);
    wr(2'd1, 8'h01);
    rd_expect(2'd1, 8'h01, "R4 clear ineffective while level high");
    chk(irq === 1'b1, "R4 irq stays with level high", {7'b0, irq}, 8'h01);
    wr(2'd1, 8'h00);
    rd_expect(2'd1, 8'h01, "R3 write zero leaves pending");
    ev[0] = 1'b0;
    wr(2'd1, 8'h01);
    chk(irq_at_ack === 1'b0, "R9 irq low during clear ack", {7'b0, irq_at_ack}, 8'h00);

    ev[1] = 1'b1;
    repeat (2) @(negedge clk);
    rd_expect(2'd1, 8'h02, "R5 rising edge latched");
    repeat (3) @(negedge clk);
    rd_expect(2'd1, 8'h02, "R5 rise pending holds");
    chk(irq === 1'b1, "R8 irq for rise event", {7'b0, irq}, 8'h01);
    wr(2'd1, 8'h02);
    chk(irq_at_ack === 1'b0, "R9 irq low during clear ack", {7'b0, irq_at_ack}, 8'h00);

    ev[2] = 1'b0;
    repeat (2) @(negedge clk);
    rd_expect(2'd1, 8'h04, "R6 falling edge latched");
    wr(2'd1, 8'h04);
    chk(irq_at_ack === 1'b0, "R9 irq low during clear ack", {7'b0, irq_at_ack}, 8'h00);
    rd_expect(2'd1, 8'h00, "R6 cleared");

    wr(2'd3, 8'hFF);
    rd_expect(2'd3, 8'h00, "R11 spare offset reads zero");
    rd_expect(2'd2, 8'h07, "R11 spare write no effect");
    wr(2'd0, 8'h00);
    rd_expect(2'd2, 8'h07, "R1 status write ignored");
    rd_expect(2'd1, 8'h00, "R1 status write ignored pending");
    wr(2'd2, 8'hFA);
    rd_expect(2'd2, 8'h02, "R2 high data bits dropped");
    wr(2'd2, 8'h07);

    ev[1] = 1'b0;
    repeat (2) @(negedge clk);
    wr(2'd1, 8'h07);
    ev[1] = 1'b1;
    wr(2'd1, 8'h02);
    rd_expect(2'd1, 8'h02, "R7 set wins over same-edge clear");
    wr(2'd1, 8'h07);

    stb = 1'b1; cyc = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(ack === 1'b0, "R10 strobe without cycle ignored", {7'b0, ack}, 8'h00);
    cyc = 1'b1; adr = 2'd0;
    @(negedge clk);
    chk(ack === 1'b1, "R10 held request first ack", {7'b0, ack}, 8'h01);
    @(negedge clk);
    chk(ack === 1'b0, "R10 held request gap", {7'b0, ack}, 8'h00);
    @(negedge clk);
    chk(ack === 1'b1, "R10 held request second ack", {7'b0, ack}, 8'h01);
    cyc = 1'b0; stb = 1'b0;
    @(negedge clk);

    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 2) == 0) ev = 3'($urandom);
      if ($urandom_range(0, 3) == 0) @(negedge clk);
      xfer(1'($urandom), 2'($urandom), 8'($urandom), "R1 R2 R3 random read vs model", r);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule